// File: doc/BRIEF.md
# Modular-Exponentiation Bus Front End

This block sits between a simple synchronous host bus and a modular-exponentiation engine. One address bit splits the space into two regions. The lower region holds a small register file: identification words, a control register, a status register, a mode register, the modulus and exponent bit widths, and two read-only capability words. The upper region holds eight operand banks of 32-bit words, which the host fills and reads back. The least significant operand word sits at word index 0.

The block supports two operations. Precompute is started by bit 0 of control, and exponentiate is started by bit 1. Each operation starts only when its control bit goes from 0 to 1, and each has its own completion flag in the status register. When the host asks for both at once, precompute wins. At the start of each operation the block latches the operand lengths: the modulus word count on both commands, and the exponent word count on exponentiate only. A stub engine stands in for the arithmetic and finishes after a latency computed from those latched lengths.

Top module: `mxp_bus_front`

## Requirements
- R1: Reads of register offsets 0x00, 0x01 and 0x02 return 0x6D6F6465, 0x78706137 and 0x302E3235, and writes to these offsets change nothing.
- R2: Offset 0x13 reads 32·2^OP_ADDR_W, the largest operand width in bits. Offset 0x14 reads ARRAY_BITS. Writes to either offset are ignored.
- R3: Register offsets with no defined register read zero, and writes to them are ignored. Writes to the status offset 0x09 are also ignored.
- R4: Read data appears on bus_rdata one cycle after a cycle with bus_cs=1 and bus_we=0. It then holds until the next read.
- R5: Control (0x08) reads back bits 1:0 as written. Mode (0x10) keeps only bit 1, the CRT select. Modulus width (0x11) and exponent width (0x12) keep their low OP_ADDR_W+6 bits.
- R6: When address MSB = 1, the next 3 bits select one of eight banks and the low OP_ADDR_W bits select a word. Every bank word is stored independently of every other bank word.
- R7: An operation starts only on a 0-to-1 change of control bit 0 (precompute) or bit 1 (exponentiate). Starting precompute clears status bit 0 (ready). Starting exponentiate clears status bit 1 (valid).
- R8: Both flags are 0 after reset. Only a finished precompute sets ready, and only a finished exponentiate sets valid.
- R9: When the block is idle and both control bits rise together, precompute runs and valid is left untouched.
- R10: Control-bit rises that arrive while an operation is running are ignored.
- R11: The stub engine runs STUB_BASE + latched modulus words + latched exponent words cycles and then raises done for exactly one cycle.
- R12: The modulus word count (width >> 5) is latched when either operation starts. The exponent word count is latched only when exponentiate starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus select for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OP_ADDR_W+4 | Word address; MSB selects the operand region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read select |

## Verification
The bench sweeps every register offset with writes and reads. A decoder that aliases offsets, accepts writes to read-only words or returns junk for holes would show a mismatch at that offset. It fills and reads back all eight banks; a wrong bank or index slice would show up as cross-bank overwrites. It measures operation latency in polls and compares the differences between runs. If a design forgets to re-latch the modulus on exponentiate, or re-latches the exponent on precompute, it shifts these counts by a known number of words. Simultaneous starts, a repeated write of 1, and starts issued during a running operation are also exercised. A design that gives exponentiate priority, detects levels instead of edges, or queues busy commands would clear or set the wrong flag.

// File: rtl/mxp_front_pkg.sv
package mxp_front_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_STOP = 2'd2
   } mxp_state_e;

   // register-region word offsets
   localparam int OFF_ID0     = 'h00;
   localparam int OFF_ID1     = 'h01;
   localparam int OFF_VER     = 'h02;
   localparam int OFF_CTRL    = 'h08;
   localparam int OFF_STAT    = 'h09;
   localparam int OFF_MODE    = 'h10;
   localparam int OFF_MODBITS = 'h11;
   localparam int OFF_EXPBITS = 'h12;
   localparam int OFF_BUFBITS = 'h13;
   localparam int OFF_ARRBITS = 'h14;

   localparam logic [31:0] ID_WORD0 = 32'h6D6F6465;
   localparam logic [31:0] ID_WORD1 = 32'h78706137;
   localparam logic [31:0] ID_VER   = 32'h302E3235;

   localparam int NUM_BANKS = 8;
   localparam int BANK_SEL_W = 3;

endpackage

// File: rtl/mxp_opbank.sv
module mxp_opbank #(
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
      if (re) rdata <= mem[idx];
   end

endmodule

// File: rtl/mxp_regfile.sv
module mxp_regfile
   import mxp_front_pkg::*;
#(
   parameter int OP_ADDR_W  = 4,
   parameter int ARRAY_BITS = 64,
   localparam int OFFS_W    = OP_ADDR_W + 3,
   localparam int BITS_W    = OP_ADDR_W + 6,
   localparam logic [31:0] BUF_BITS = 32'(32) << OP_ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OFFS_W-1:0] offset,
   input  logic [31:0]       wdata,
   input  logic              stat_ready,
   input  logic              stat_valid,
   output logic [31:0]       rdata,
   output logic [BITS_W-1:0] mod_bits,
   output logic [BITS_W-1:0] exp_bits,
   output logic              init_p,
   output logic              next_p
);

   logic [1:0]        ctrl_q;
   logic              crt_q;
   logic [BITS_W-1:0] mod_bits_q;
   logic [BITS_W-1:0] exp_bits_q;
   logic [31:0]       rdata_q;
   logic              init_p_q;
   logic              next_p_q;
   logic [31:0]       off32;
   logic [31:0]       rd_val;
   logic              hit_ctrl;
   wire               unused_wbits = ^wdata[31:BITS_W];

   assign off32    = 32'(offset);
   assign hit_ctrl = wr_en && (off32 == OFF_CTRL);

   always_comb begin
      case (off32)
         OFF_ID0:     rd_val = ID_WORD0;
         OFF_ID1:     rd_val = ID_WORD1;
         OFF_VER:     rd_val = ID_VER;
         OFF_CTRL:    rd_val = {30'd0, ctrl_q};
         OFF_STAT:    rd_val = {30'd0, stat_valid, stat_ready};
         OFF_MODE:    rd_val = {30'd0, crt_q, 1'b0};
         OFF_MODBITS: rd_val = 32'(mod_bits_q);
         OFF_EXPBITS: rd_val = 32'(exp_bits_q);
         OFF_BUFBITS: rd_val = BUF_BITS;
         OFF_ARRBITS: rd_val = 32'(ARRAY_BITS);
         default:     rd_val = 32'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= 2'b00;
         crt_q      <= 1'b0;
         mod_bits_q <= '0;
         exp_bits_q <= '0;
         rdata_q    <= 32'd0;
         init_p_q   <= 1'b0;
         next_p_q   <= 1'b0;
      end else begin
         init_p_q <= hit_ctrl && wdata[0] && !ctrl_q[0];
         next_p_q <= hit_ctrl && wdata[1] && !ctrl_q[1];
         if (wr_en) begin
            case (off32)
               OFF_CTRL:    ctrl_q     <= wdata[1:0];
               OFF_MODE:    crt_q      <= wdata[1];
               OFF_MODBITS: mod_bits_q <= wdata[BITS_W-1:0];
               OFF_EXPBITS: exp_bits_q <= wdata[BITS_W-1:0];
               default:     ;
            endcase
         end
         if (rd_en) rdata_q <= rd_val;
      end
   end

   assign rdata    = rdata_q;
   assign mod_bits = mod_bits_q;
   assign exp_bits = exp_bits_q;
   assign init_p   = init_p_q;
   assign next_p   = next_p_q;

endmodule

// File: rtl/mxp_seq.sv
module mxp_seq
   import mxp_front_pkg::*;
#(
   parameter int BITS_W  = 10,
   localparam int WORDS_W = BITS_W - 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_p,
   input  logic               next_p,
   input  logic [BITS_W-1:0]  mod_bits,
   input  logic [BITS_W-1:0]  exp_bits,
   input  logic               eng_done,
   output mxp_state_e         st,
   output logic               op_init,
   output logic               ready,
   output logic               valid,
   output logic [WORDS_W-1:0] mod_w_l,
   output logic [WORDS_W-1:0] exp_w_l
);

   wire unused_lowbits = ^{mod_bits[4:0], exp_bits[4:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         op_init <= 1'b0;
         ready   <= 1'b0;
         valid   <= 1'b0;
         mod_w_l <= '0;
         exp_w_l <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (init_p || next_p) begin
                  st      <= ST_RUN;
                  op_init <= init_p;
                  mod_w_l <= mod_bits[BITS_W-1:5];
                  if (init_p) begin
                     ready <= 1'b0;
                  end else begin
                     valid   <= 1'b0;
                     exp_w_l <= exp_bits[BITS_W-1:5];
                  end
               end
            end
            ST_RUN: begin
               if (eng_done) st <= ST_STOP;
            end
            ST_STOP: begin
               if (op_init) ready <= 1'b1;
               else         valid <= 1'b1;
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mxp_engine_stub.sv
module mxp_engine_stub #(
   parameter int WORDS_W = 5,
   parameter int BASE    = 6,
   localparam int CNT_W  = WORDS_W + 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [WORDS_W-1:0] mod_w,
   input  logic [WORDS_W-1:0] exp_w,
   output logic               done
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;

   assign target = CNT_W'(BASE) + CNT_W'(mod_w) + CNT_W'(exp_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
      else          cnt <= '0;
   end

   assign done = run && (cnt == target);

endmodule

// File: rtl/mxp_bus_front.sv
module mxp_bus_front
   import mxp_front_pkg::*;
#(
   parameter int OP_ADDR_W  = 4,
   parameter int ARRAY_BITS = 64,
   parameter int STUB_BASE  = 6,
   localparam int ADDR_W    = OP_ADDR_W + 4,
   localparam int OFFS_W    = OP_ADDR_W + 3,
   localparam int BITS_W    = OP_ADDR_W + 6,
   localparam int WORDS_W   = BITS_W - 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);

   if (OP_ADDR_W < 2 || OP_ADDR_W > 12) begin : g_bad_addr_w
      $error("OP_ADDR_W must lie in 2..12");
   end
   if (STUB_BASE < 1 || STUB_BASE > 255) begin : g_bad_base
      $error("STUB_BASE must lie in 1..255");
   end

   logic                  region_op;
   logic [BANK_SEL_W-1:0] bank_sel;
   logic [OP_ADDR_W-1:0]  word_idx;
   logic                  reg_wr, reg_rd;
   logic [31:0]           reg_rdata;
   logic [BITS_W-1:0]     mod_bits, exp_bits;
   logic                  init_p, next_p;
   mxp_state_e            st;
   logic                  op_init, ready, valid, eng_done;
   logic [WORDS_W-1:0]    mod_w_l, exp_w_l;
   logic [31:0]           bank_rd [NUM_BANKS];
   logic                  rsel_op_q;
   logic [BANK_SEL_W-1:0] rbank_q;

   assign region_op = bus_addr[ADDR_W-1];
   assign bank_sel  = bus_addr[ADDR_W-2 -: BANK_SEL_W];
   assign word_idx  = bus_addr[OP_ADDR_W-1:0];
   assign reg_wr    = bus_cs && bus_we && !region_op;
   assign reg_rd    = bus_cs && !bus_we && !region_op;

   mxp_regfile #(.OP_ADDR_W(OP_ADDR_W), .ARRAY_BITS(ARRAY_BITS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .rd_en      (reg_rd),
      .offset     (bus_addr[OFFS_W-1:0]),
      .wdata      (bus_wdata),
      .stat_ready (ready),
      .stat_valid (valid),
      .rdata      (reg_rdata),
      .mod_bits   (mod_bits),
      .exp_bits   (exp_bits),
      .init_p     (init_p),
      .next_p     (next_p)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      assign hit = bus_cs && region_op && (bank_sel == BANK_SEL_W'(g));
      mxp_opbank #(.IDX_W(OP_ADDR_W), .DATA_W(32)) u_bank (
         .clk   (clk),
         .we    (hit && bus_we),
         .re    (hit && !bus_we),
         .idx   (word_idx),
         .wdata (bus_wdata),
         .rdata (bank_rd[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsel_op_q <= 1'b0;
         rbank_q   <= '0;
      end else if (bus_cs && !bus_we) begin
         rsel_op_q <= region_op;
         rbank_q   <= bank_sel;
      end
   end

   assign bus_rdata = rsel_op_q ? bank_rd[rbank_q] : reg_rdata;

   mxp_seq #(.BITS_W(BITS_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_p   (init_p),
      .next_p   (next_p),
      .mod_bits (mod_bits),
      .exp_bits (exp_bits),
      .eng_done (eng_done),
      .st       (st),
      .op_init  (op_init),
      .ready    (ready),
      .valid    (valid),
      .mod_w_l  (mod_w_l),
      .exp_w_l  (exp_w_l)
   );

   mxp_engine_stub #(.WORDS_W(WORDS_W), .BASE(STUB_BASE)) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_RUN),
      .mod_w (mod_w_l),
      .exp_w (exp_w_l),
      .done  (eng_done)
   );

endmodule

// File: rtl/mxp_front_chk.sv
module mxp_front_chk
   import mxp_front_pkg::*;
#(
   parameter int WORDS_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_cs,
   input logic               bus_we,
   input logic [31:0]        bus_rdata,
   input mxp_state_e         st,
   input logic               op_init,
   input logic               ready,
   input logic               valid,
   input logic               init_p,
   input logic               eng_done,
   input logic [WORDS_W-1:0] mod_w_l
);

   // R8
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(st == ST_STOP && op_init));

   // R8
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(st == ST_STOP && !op_init));

   // R7
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(st == ST_IDLE && init_p));

   // R12
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && $past(st == ST_RUN)) |-> $stable(mod_w_l));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !eng_done);

   // R4
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_cs && !bus_we) |-> $stable(bus_rdata));

endmodule

bind mxp_bus_front mxp_front_chk #(.WORDS_W(WORDS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cs    (bus_cs),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .st        (st),
   .op_init   (op_init),
   .ready     (ready),
   .valid     (valid),
   .init_p    (init_p),
   .eng_done  (eng_done),
   .mod_w_l   (mod_w_l)
);

// File: tb/mxp_bus_front_tb.sv
module mxp_bus_front_tb;

   localparam int OP_ADDR_W = 4;
   localparam int ARRAY_BITS = 64;
   localparam int ADDR_W = OP_ADDR_W + 4;
   localparam int NREG = 1 << (OP_ADDR_W + 3);
   localparam int NWORD = 1 << OP_ADDR_W;
   localparam logic [31:0] WMASK = (32'd1 << (OP_ADDR_W + 6)) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_cs = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mxp_bus_front #(.OP_ADDR_W(OP_ADDR_W), .ARRAY_BITS(ARRAY_BITS), .STUB_BASE(6)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_cs    (bus_cs),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // tasks start and end at a falling edge
   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_cs = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] reg_model(input int off, input logic [31:0] w);
      case (off)
         'h00: return 32'h6D6F6465;
         'h01: return 32'h78706137;
         'h02: return 32'h302E3235;
         'h08: return 32'd0;
         'h09: return 32'd0;
         'h10: return w & 32'h2;
         'h11, 'h12: return w & WMASK;
         'h13: return 32'(32 << OP_ADDR_W);
         'h14: return 32'(ARRAY_BITS);
         default: return 32'd0;
      endcase
   endfunction

   // start an operation with a 0 then v write; report the first status and the polls until 'bitpos' is set
   task automatic run_op(input logic [1:0] v, input int bitpos, output logic [31:0] first, output int polls);
      logic [31:0] s;
      bus_wr(ADDR_W'('h08), 32'd0);
      bus_wr(ADDR_W'('h08), 32'(v));
      repeat (2) @(negedge clk);
      bus_rd(ADDR_W'('h09), first);
      polls = 0;
      s = first;
      while (!s[bitpos] && polls < 2000) begin
         bus_rd(ADDR_W'('h09), s);
         polls++;
      end
   endtask

   initial begin
      logic [31:0] d, first;
      int pa, pb, pc, pd, pe, px;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      bus_rd(ADDR_W'('h09), d);
      check("R8 status after reset", d, 32'd0);

      // R1 R2 R3 R5: sweep every register offset except control
      for (int off = 0; off < NREG; off++) begin
         if (off != 'h08) bus_wr(ADDR_W'(off), 32'hA5C3_0000 ^ 32'(off * 32'h0101_0037));
      end
      for (int off = 0; off < NREG; off++) begin
         bus_rd(ADDR_W'(off), d);
         check($sformatf("R1/R2/R3/R5 reg offset 0x%02h", off), d,
               reg_model(off, 32'hA5C3_0000 ^ 32'(off * 32'h0101_0037)));
      end
      bus_wr(ADDR_W'('h10), 32'hFFFF_FFFF);
      bus_rd(ADDR_W'('h10), d);
      check("R5 mode keeps bit 1 only", d, 32'h2);

      // R6: all banks, all words
      for (int b = 0; b < 8; b++)
         for (int i = 0; i < NWORD; i++)
            bus_wr(ADDR_W'((1 << (ADDR_W - 1)) | (b << OP_ADDR_W) | i), 32'h1000_0000 * b + 32'h0003_0101 * i + 32'h55);
      for (int b = 0; b < 8; b++)
         for (int i = 0; i < NWORD; i++) begin
            bus_rd(ADDR_W'((1 << (ADDR_W - 1)) | (b << OP_ADDR_W) | i), d);
            check($sformatf("R6 bank %0d word %0d", b, i), d, 32'h1000_0000 * b + 32'h0003_0101 * i + 32'h55);
         end

      // R4: read data holds across idle cycles and writes
      bus_rd(ADDR_W'('h01), d);
      bus_wr(ADDR_W'('h10), 32'h0);
      repeat (3) @(negedge clk);
      check("R4 read data held", bus_rdata, 32'h78706137);

      // R7 R8 R11 R12: latency differences reveal latched lengths
      bus_wr(ADDR_W'('h11), 32'd256);
      bus_wr(ADDR_W'('h12), 32'd96);
      run_op(2'b01, 0, first, pa);
      check("R7 init clears ready", first, 32'd0);
      bus_rd(ADDR_W'('h09), d);
      check("R8 precompute sets only ready", d, 32'd1);

      bus_wr(ADDR_W'('h11), 32'd128);
      run_op(2'b01, 0, first, pb);
      check("R12 modulus latched on init", 32'(pa - pb), 32'd4);

      bus_wr(ADDR_W'('h12), 32'd256);
      run_op(2'b10, 1, first, pc);
      check("R7 next clears valid keeps ready", first, 32'd1);
      check("R11 exponent words add to latency", 32'(pc - pb), 32'd8);
      bus_rd(ADDR_W'('h09), d);
      check("R8 exponentiate sets valid", d, 32'd3);

      bus_wr(ADDR_W'('h11), 32'd256);
      bus_wr(ADDR_W'('h12), 32'd32);
      run_op(2'b01, 0, first, pd);
      check("R12 exponent not latched on init", 32'(pd - pb), 32'd12);

      bus_wr(ADDR_W'('h11), 32'd128);
      run_op(2'b10, 1, first, pe);
      check("R12 modulus re-latched on next", 32'(pe - pb), 32'd1);

      // R9: both bits rise together
      run_op(2'b11, 0, first, px);
      check("R9 init wins, valid untouched", first, 32'd2);
      bus_rd(ADDR_W'('h09), d);
      check("R9 both flags set after init", d, 32'd3);

      // R7: writing 1 over 1 is no start
      bus_wr(ADDR_W'('h08), 32'd3);
      repeat (3) @(negedge clk);
      bus_rd(ADDR_W'('h09), d);
      check("R7 no start without 0-to-1", d, 32'd3);

      // R10: next edge while busy is dropped
      bus_wr(ADDR_W'('h08), 32'd0);
      bus_wr(ADDR_W'('h08), 32'd1);
      repeat (2) @(negedge clk);
      bus_wr(ADDR_W'('h08), 32'd0);
      bus_wr(ADDR_W'('h08), 32'd2);
      bus_rd(ADDR_W'('h09), d);
      check("R10 busy: ready still clear", d, 32'd2);
      repeat (60) @(negedge clk);
      bus_rd(ADDR_W'('h09), d);
      check("R10 busy edge ignored", d, 32'd3);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule